// File: doc/BRIEF.md
# Configurable UART frame transmitter

This block turns one data word into an asynchronous serial frame on a single transmit line. Before each word, settings choose a data length of 5 to 8 bits, an optional bit after the data, and one or two stop bits. The bit after the data is either a parity bit computed in hardware or an extra bit supplied with the word.

A ready/valid handshake loads the word, together with the extra-bit value when that mode is on. All bit timing comes from a one-clock `bit_tick` strobe made by an external baud generator. After a word is accepted, the transmitter waits for the next tick. From that tick on, every bit of the frame lasts exactly one tick period.

The `busy` output covers the frame from the moment the word is accepted until the last stop bit ends. `done` is a one-clock pulse that marks the end of the frame.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset and between frames `tx_out` is 1. The start bit is 0 and runs from the first `bit_tick` after acceptance to the next `bit_tick`.
- R2: Data bits follow the start bit, least significant bit first, one per tick period. `cfg_len` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits.
- R3: With `cfg_par_en`=1, one parity bit follows the data bits. `cfg_par_kind` selects its value: 0 is even (XOR of the sent data bits), 1 is odd (XNOR of the sent data bits), 2 is mark (constant 1) and 3 is space (constant 0).
- R4: With `cfg_xbit_en`=1 and `cfg_par_en`=0, the `in_xbit` value captured with the word is sent after the data bits. When both are set, the parity bit is sent instead.
- R5: The frame ends with high stop bits. There are two when `cfg_two_stop`=1 and one otherwise.
- R6: When `cfg_len`=0 (5 data bits), exactly one stop bit is sent, whatever the value of `cfg_two_stop`.
- R7: All settings are captured when the word is accepted. Changing them during a frame does not alter that frame.
- R8: `in_ready` is 1 only while idle. `busy` is 1 from the cycle after acceptance until the frame ends. `in_valid` asserted during a frame is ignored and does not change the frame.
- R9: `done` is high for exactly one clock, in the cycle after the tick that ends the last stop bit. In that same cycle `busy` has dropped.
- R10: When `rst_n` is asserted in the middle of a frame, the frame is abandoned at once. `tx_out`=1, `busy`=0 and `done`=0 follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-clock strobe per bit period |
| cfg_len | input | 2 | Data length code (0..3 gives 5..8 bits) |
| cfg_par_en | input | 1 | Enable the parity bit |
| cfg_par_kind | input | 2 | Parity kind: 0 even, 1 odd, 2 mark, 3 space |
| cfg_xbit_en | input | 1 | Enable the extra bit |
| cfg_two_stop | input | 1 | Request two stop bits |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Word can be taken (idle) |
| in_data | input | 8 | Data word |
| in_xbit | input | 1 | Extra-bit value |
| tx_out | output | 1 | Serial line |
| busy | output | 1 | Frame in progress |
| done | output | 1 | End-of-frame pulse |

## Verification
- **First tick after acceptance:** nothing changes on the line at this tick. Each bit then appears on `tx_out` in the cycle after the tick that starts it and holds until the next tick edge. The bench therefore samples the line on the falling clock edge of each tick cycle, which shows the bit that this tick ends.
- **`busy` and `in_ready`:** both change in the cycle right after the accepting edge, and are checked at the falling edge of that cycle.
- **`done`:** it is due exactly one cycle after the tick that ends the last stop bit, and is checked there and again one cycle later to confirm it has cleared.
- **Reset:** it acts with no clock edge, so the idle outputs are checked at the falling edge that follows it.

// File: rtl/uftx_pkg.sv
package uftx_pkg;

  typedef enum logic [1:0] {
    PAR_EVEN  = 2'd0,
    PAR_ODD   = 2'd1,
    PAR_MARK  = 2'd2,
    PAR_SPACE = 2'd3
  } par_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ALIGN = 3'd1,
    ST_START = 3'd2,
    ST_DATA  = 3'd3,
    ST_EXTRA = 3'd4,
    ST_STOP  = 3'd5
  } tx_state_e;

endpackage

// File: rtl/uftx_rst_sync.sv
module uftx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/uftx_parity.sv
module uftx_parity
  import uftx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data,
  input  logic [CNT_W-1:0]  last_idx,
  input  par_kind_e         kind,
  output logic              par_bit
);

  logic [DATA_W-1:0] masked;

  // only the bits that will be sent take part in the parity sum
  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign masked[i] = data[i] & (CNT_W'(i) <= last_idx);
  end

  always_comb begin
    unique case (kind)
      PAR_EVEN:  par_bit = ^masked;
      PAR_ODD:   par_bit = ~(^masked);
      PAR_MARK:  par_bit = 1'b1;
      default:   par_bit = 1'b0;
    endcase
  end

endmodule

// File: rtl/uftx_shreg.sv
module uftx_shreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              shift_en,
  input  logic [DATA_W-1:0] load_val,
  output logic              lsb
);

  logic [DATA_W-1:0] sr_q;
  logic [DATA_W-1:0] sr_d;

  always_comb begin
    sr_d = sr_q;
    if (load_en) begin
      sr_d = load_val;
    end else if (shift_en) begin
      sr_d = {1'b0, sr_q[DATA_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (load_en || shift_en) begin
      sr_q <= sr_d;
    end
  end

  assign lsb = sr_q[0];

endmodule

// File: rtl/uftx_seq.sv
module uftx_seq
  import uftx_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             accept,
  input  logic [CNT_W-1:0] last_idx,
  input  logic             has_extra,
  input  logic             two_stop,
  output tx_state_e        state,
  output logic             shift_en,
  output logic             done
);

  tx_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    done_d   = 1'b0;
    shift_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) state_d = ST_ALIGN;
      end
      ST_ALIGN: begin
        if (bit_tick) state_d = ST_START;
      end
      ST_START: begin
        if (bit_tick) begin
          state_d = ST_DATA;
          cnt_d   = '0;
        end
      end
      ST_DATA: begin
        if (bit_tick) begin
          shift_en = 1'b1;
          if (cnt_q == last_idx) begin
            state_d = has_extra ? ST_EXTRA : ST_STOP;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_EXTRA: begin
        if (bit_tick) begin
          state_d = ST_STOP;
          cnt_d   = '0;
        end
      end
      ST_STOP: begin
        if (bit_tick) begin
          if (two_stop && (cnt_q == '0)) begin
            cnt_d = CNT_W'(1);
          end else begin
            state_d = ST_IDLE;
            cnt_d   = '0;
            done_d  = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign state = state_q;
  assign done  = done_q;

  // R1
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && !bit_tick) |=> $stable(state_q));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (state_q == ST_IDLE));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA) |-> (cnt_q <= last_idx));

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uftx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MIN_LEN = 5,
  localparam int CNT_W  = $clog2(DATA_W),
  localparam int LEN_W  = $clog2(DATA_W - MIN_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_par_en,
  input  logic [1:0]        cfg_par_kind,
  input  logic              cfg_xbit_en,
  input  logic              cfg_two_stop,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_xbit,
  output logic              tx_out,
  output logic              busy,
  output logic              done
);

  logic             rst_i_n;
  tx_state_e        state;
  logic             shift_en;
  logic             accept;
  logic             data_lsb;
  logic             par_bit;

  logic [CNT_W-1:0] last_idx_d, last_idx_q;
  logic             has_extra_d, has_extra_q;
  logic             two_stop_d, two_stop_q;
  logic             xval_d, xval_q;
  logic             short_d, short_q;

  uftx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  assign in_ready = (state == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign busy     = !in_ready;

  // settings decoded from the live inputs, captured only on accept
  always_comb begin
    last_idx_d  = CNT_W'(MIN_LEN - 1) + CNT_W'(cfg_len);
    short_d     = (cfg_len == '0);
    two_stop_d  = cfg_two_stop && !short_d;
    has_extra_d = cfg_par_en || cfg_xbit_en;
    xval_d      = cfg_par_en ? par_bit : in_xbit;
  end

  uftx_parity #(.DATA_W(DATA_W)) u_par (
    .data     (in_data),
    .last_idx (last_idx_d),
    .kind     (par_kind_e'(cfg_par_kind)),
    .par_bit  (par_bit)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      last_idx_q  <= '0;
      has_extra_q <= 1'b0;
      two_stop_q  <= 1'b0;
      xval_q      <= 1'b0;
      short_q     <= 1'b0;
    end else if (accept) begin
      last_idx_q  <= last_idx_d;
      has_extra_q <= has_extra_d;
      two_stop_q  <= two_stop_d;
      xval_q      <= xval_d;
      short_q     <= short_d;
    end
  end

  uftx_shreg #(.DATA_W(DATA_W)) u_sr (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load_en  (accept),
    .shift_en (shift_en),
    .load_val (in_data),
    .lsb      (data_lsb)
  );

  uftx_seq #(.CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .bit_tick  (bit_tick),
    .accept    (accept),
    .last_idx  (last_idx_q),
    .has_extra (has_extra_q),
    .two_stop  (two_stop_q),
    .state     (state),
    .shift_en  (shift_en),
    .done      (done)
  );

  always_comb begin
    unique case (state)
      ST_START: tx_out = 1'b0;
      ST_DATA:  tx_out = data_lsb;
      ST_EXTRA: tx_out = xval_q;
      default:  tx_out = 1'b1;
    endcase
  end

  // R1
  fall_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    $fell(tx_out) |-> busy);

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (busy && $past(busy)) |-> ($stable(last_idx_q) && $stable(two_stop_q) &&
                               $stable(has_extra_q) && $stable(xval_q)));

  // R6
  short_one_stop_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (short_q && state == ST_STOP && bit_tick) |=> done);

  // R8
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (busy && in_valid) |=> !$rose(in_ready) || done);

endmodule

// File: tb/uart_frame_tx_test.sv
module uart_frame_tx_test;

  localparam int TICK_DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_tick;
  logic [1:0] cfg_len;
  logic       cfg_par_en;
  logic [1:0] cfg_par_kind;
  logic       cfg_xbit_en;
  logic       cfg_two_stop;
  logic       in_valid;
  logic       in_ready;
  logic [7:0] in_data;
  logic       in_xbit;
  logic       tx_out;
  logic       busy;
  logic       done;

  int n_chk  = 0;
  int n_fail = 0;
  bit summary_done = 1'b0;
  int cyc = 0;
  int tick_cnt = 0;

  always #2.5 clk = ~clk;

  uart_frame_tx uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_tick     (bit_tick),
    .cfg_len      (cfg_len),
    .cfg_par_en   (cfg_par_en),
    .cfg_par_kind (cfg_par_kind),
    .cfg_xbit_en  (cfg_xbit_en),
    .cfg_two_stop (cfg_two_stop),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_data      (in_data),
    .in_xbit      (in_xbit),
    .tx_out       (tx_out),
    .busy         (busy),
    .done         (done)
  );

  // baud strobe, updated like a register
  always @(posedge clk) begin
    tick_cnt <= (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
    bit_tick <= (tick_cnt == TICK_DIV - 1);
  end

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
      summary();
    end
  end

  task automatic check(string req, logic act, logic exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // vector layout: [15:14] len, [13] par_en, [12:11] kind, [10] xen,
  //                [9] xbit, [8] two_stop, [7:0] data
  localparam logic [15:0] VEC [8] = '{
    {2'd3, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 8'hA5},
    {2'd0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 8'h1B},
    {2'd1, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 8'h2C},
    {2'd2, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 8'h7F},
    {2'd3, 1'b1, 2'd3, 1'b0, 1'b0, 1'b1, 8'h80},
    {2'd3, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 8'h3C},
    {2'd3, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 8'hF1},
    {2'd1, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 8'h15}
  };

  // mode: 0 plain, 1 change settings mid-frame, 2 offer another word mid-frame
  task automatic send(logic [15:0] v, int mode);
    logic [11:0] exp;
    string       req [12];
    int          total;
    int          n;
    logic        pb;
    int          idx;
    bit          aligned;
    int          guard;
    n     = 5 + int'(v[15:14]);
    total = 0;
    exp[total] = 1'b0; req[total] = "R1"; total++;
    for (int i = 0; i < n; i++) begin
      exp[total] = v[i]; req[total] = "R2"; total++;
    end
    if (v[13]) begin
      pb = 1'b0;
      for (int i = 0; i < n; i++) pb ^= v[i];
      case (v[12:11])
        2'd0: exp[total] = pb;
        2'd1: exp[total] = ~pb;
        2'd2: exp[total] = 1'b1;
        default: exp[total] = 1'b0;
      endcase
      req[total] = "R3"; total++;
    end else if (v[10]) begin
      exp[total] = v[9]; req[total] = "R4"; total++;
    end
    exp[total] = 1'b1; req[total] = (n == 5) ? "R6" : "R5"; total++;
    if (v[8] && n > 5) begin
      exp[total] = 1'b1; req[total] = "R5"; total++;
    end
    if (mode == 1) for (int i = 0; i < total; i++) req[i] = "R7";
    if (mode == 2) for (int i = 0; i < total; i++) req[i] = "R8";

    @(negedge clk);
    check("R8", in_ready, 1'b1, "in_ready while idle");
    {cfg_len, cfg_par_en, cfg_par_kind, cfg_xbit_en, in_xbit, cfg_two_stop, in_data} = v;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R8", busy, 1'b1, "busy after accept");
    check("R8", in_ready, 1'b0, "in_ready after accept");
    check("R1", tx_out, 1'b1, "line before first tick");
    if (mode == 1) begin
      cfg_len = ~v[15:14]; cfg_par_en = ~v[13]; cfg_par_kind = ~v[12:11];
      cfg_xbit_en = ~v[10]; in_xbit = ~v[9]; cfg_two_stop = ~v[8]; in_data = ~v[7:0];
    end
    idx = 0; aligned = 1'b0; guard = 0;
    while (idx < total && guard < 400) begin
      if (bit_tick) begin
        if (!aligned) aligned = 1'b1;
        else begin
          check(req[idx], tx_out, exp[idx], $sformatf("frame bit %0d", idx));
          check("R8", busy, 1'b1, "busy in frame");
          idx++;
          if (mode == 2 && idx == 3) begin in_valid = 1'b1; in_data = ~v[7:0]; end
          if (mode == 2 && idx == total - 1) in_valid = 1'b0;
        end
      end
      guard++;
      @(negedge clk);
    end
    // last sample was at the tick cycle; now one cycle past it
    check("R9", done, 1'b1, "done after last stop");
    check("R9", busy, 1'b0, "busy after last stop");
    check("R1", tx_out, 1'b1, "idle line");
    @(negedge clk);
    check("R9", done, 1'b0, "done cleared");
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_xbit = 1'b0;
    cfg_len = '0; cfg_par_en = 1'b0; cfg_par_kind = '0; cfg_xbit_en = 1'b0;
    cfg_two_stop = 1'b0;
    repeat (3) @(negedge clk);
    check("R10", tx_out, 1'b1, "reset line");
    check("R10", busy, 1'b0, "reset busy");
    check("R10", done, 1'b0, "reset done");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", tx_out, 1'b1, "idle after reset");

    for (int k = 0; k < 8; k++) send(VEC[k], 0);

    // R7: settings and word changed mid-frame
    send({2'd2, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 8'h5A}, 1);
    // R8: second word offered while busy
    send({2'd3, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 8'hC3}, 2);
    // R6 with 5 bits and two-stop request, extra bit on
    send({2'd0, 1'b0, 2'd0, 1'b1, 1'b1, 1'b1, 8'h0A}, 0);

    // R10: reset in the middle of a frame
    @(negedge clk);
    {cfg_len, cfg_par_en, cfg_par_kind, cfg_xbit_en, in_xbit, cfg_two_stop, in_data} =
      {2'd3, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00};
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (9) @(negedge clk);
    check("R10", tx_out, 1'b0, "line low mid-frame before reset");
    rst_n = 1'b0;
    @(negedge clk);
    check("R10", tx_out, 1'b1, "line after mid-frame reset");
    check("R10", busy, 1'b0, "busy after mid-frame reset");
    check("R10", done, 1'b0, "done after mid-frame reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    send(VEC[0], 0);

    summary();
  end

endmodule